// File: doc/BRIEF.md
# Peripheral-to-memory block mover

This controller copies a run of bytes from a single I/O device straight into system memory, so the processor never carries the data itself. Software presents a destination address, a byte count and a bus-sharing policy, then pulses a start input. The controller wins the system buses through a request/grant exchange with the processor. It takes a byte from the device on a valid/ack handshake, writes it to memory, steps the address up and the remaining count down, and raises a sticky completion flag when the count is used up.

Three policies decide how the buses are shared. In the first, the controller keeps the buses from the first grant until the whole block is written. In the second, it gives the buses back after every byte and then asks again. In the third, it keeps its request up but writes only in cycles where the processor reports that it is busy inside and has no use for the buses. The address, data and write-enable outputs count as driven only while a drive-enable output is high, and that happens only while the request and the grant are both high.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the outputs `bus_req`, `mem_we`, `dev_ack`, `bus_drive` and `done` are all 0.
- R2: `bus_drive` is 1 only while `bus_req` and `bus_grant` are both 1. While `bus_drive` is 0, `mem_addr`, `mem_data` and `mem_we` are all 0. While the request is up without a grant, no write occurs.
- R3: A memory write happens only in a cycle with the buses granted and `dev_valid` high. `dev_ack` is high in exactly the cycles in which `mem_we` is high, and in those cycles `mem_data` equals `dev_data`.
- R4: The n-th byte of a block (counting from 0) is written to the start address plus n, modulo 2^ADDR_W. Exactly the programmed number of bytes is written.
- R5: With `cfg_mode` = 2'b00 (hold-the-bus policy), `bus_req` rises in the cycle after start and stays high without a break until the final byte is written. It is low from the cycle after the final write.
- R6: With `cfg_mode` = 2'b01 (one-byte-per-grant policy), `bus_req` is low for exactly one cycle after every byte that is not the last, and then it is raised again.
- R7: With `cfg_mode` = 2'b10 (idle-cycle policy), a write happens only in a cycle with `bus_idle` high. When `bus_idle` is low, the controller writes nothing and keeps its position.
- R8: `done` is set in the cycle after the final write and stays set until the next accepted start clears it. A start with a count of 0 sets `done` without ever raising `bus_req`.
- R9: A start pulse during an active block is ignored. Addresses and byte count carry on from the original programming.
- R10: `cfg_mode` = 2'b11 behaves exactly like 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | 1 | One-cycle pulse that begins a block |
| cfg_addr | input | ADDR_W | First memory address of the block |
| cfg_count | input | CNT_W | Number of bytes to move |
| cfg_mode | input | 2 | Bus-sharing policy: 00 hold, 01 per-byte, 10 idle-cycle, 11 hold |
| done | output | 1 | Sticky completion flag |
| bus_req | output | 1 | Request for the system buses |
| bus_grant | input | 1 | Grant from the processor |
| bus_idle | input | 1 | Processor is not using the buses this cycle |
| bus_drive | output | 1 | Address, data and write-enable are being driven |
| mem_addr | output | ADDR_W | Memory address |
| mem_data | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| dev_valid | input | 1 | Device has a byte ready |
| dev_data | input | DATA_W | Byte from the device |
| dev_ack | output | 1 | Byte taken from the device |

## Verification
On every cycle the assertions check how the write strobe relates to grant, device valid and acknowledge. They also check the address step after each write, the one-cycle gap after each byte in the per-byte policy, that the request is held in the hold policy, that writes happen only in idle cycles in the idle-cycle policy, and that the completion flag is sticky. Only the bench's scenarios can show the parts that depend on a whole block: the exact set of addresses and the data values written, the total number of bytes, that a start arriving in mid-block changes nothing, and that a zero-length start finishes without a bus request.

// File: rtl/dma_xfer_pkg.sv
// Shared encodings for the block mover.
// Assumes: the mode field is two bits wide, and 2'b11 is an alias of the hold policy.
package dma_xfer_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_STEAL = 2'b01,
        MODE_QUIET = 2'b10,
        MODE_ALIAS = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_OWN  = 2'b01,
        ST_GAP  = 2'b10
    } ctl_state_e;
endpackage

// File: rtl/dma_xfer_regs.sv
// Address pointer, remaining-count register and sticky done flag.
// Assumes: load and step never arrive together; set_done wins over clr_done.
module dma_xfer_regs #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_count,
    input  logic              step,
    input  logic              set_done,
    input  logic              clr_done,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  count_q,
    output logic              last_byte,
    output logic              done
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0]  CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    // Pointer and counter: load on start, step once per written byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            count_q <= '0;
        end else if (load) begin
            addr_q  <= load_addr;
            count_q <= load_count;
        end else if (step) begin
            addr_q  <= addr_q + ADDR_ONE;
            count_q <= count_q - CNT_ONE;
        end
    end

    // Sticky completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        done <= 1'b0;
        else if (set_done) done <= 1'b1;
        else if (clr_done) done <= 1'b0;
    end

    // Flags the byte that empties the counter.
    always_comb last_byte = (count_q == CNT_ONE);
endmodule

// File: rtl/dma_xfer_seq.sv
// Bus-ownership sequencer: request/grant handling and per-policy write qualification.
// Assumes: the processor keeps its outputs released while the request is high.
module dma_xfer_seq
    import dma_xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       zero_len,
    input  logic [1:0] mode_in,
    input  logic       bg,
    input  logic       bus_idle,
    input  logic       dev_valid,
    input  logic       last_byte,
    output logic       br,
    output logic       wr,
    output logic       load,
    output logic       set_done,
    output logic       clr_done,
    output logic [1:0] mode_q
);
    ctl_state_e state_q, state_d;
    logic       steal_mode;
    logic       quiet_mode;
    logic       idle_ok;

    // Policy decode of the latched mode.
    always_comb begin
        steal_mode = (mode_q == MODE_STEAL);
        quiet_mode = (mode_q == MODE_QUIET);
        idle_ok    = !quiet_mode || bus_idle;
    end

    // Write qualification: bus owned, granted, byte present, policy satisfied.
    always_comb wr = (state_q == ST_OWN) && bg && dev_valid && idle_ok;

    // Request follows ownership state.
    always_comb br = (state_q == ST_OWN);

    // Start handling and completion strobes.
    always_comb begin
        load     = (state_q == ST_IDLE) && start && !zero_len;
        clr_done = load;
        set_done = ((state_q == ST_IDLE) && start && zero_len) || (wr && last_byte);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load) state_d = ST_OWN;
            ST_OWN: begin
                if (wr) begin
                    if (last_byte)       state_d = ST_IDLE;
                    else if (steal_mode) state_d = ST_GAP;
                end
            end
            ST_GAP:  state_d = ST_OWN;
            default: state_d = ST_IDLE;
        endcase
    end

    // State and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_HOLD;
        end else begin
            state_q <= state_d;
            if (load) mode_q <= mode_in;
        end
    end
endmodule

// File: rtl/dma_xfer_bus.sv
// System-bus output stage: gates address, data and strobe with the drive enable.
// Assumes: wr is only raised while the grant is present.
module dma_xfer_bus #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              br,
    input  logic              bg,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dev_data,
    output logic              bus_drive,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              mem_we,
    output logic              dev_ack
);
    // Drive only while both sides agree on ownership; released lines read as zero.
    always_comb begin
        bus_drive = br && bg;
        mem_addr  = bus_drive ? addr : '0;
        mem_data  = (bus_drive && wr) ? dev_data : '0;
        mem_we    = bus_drive && wr;
        dev_ack   = bus_drive && wr;
    end
endmodule

// File: rtl/dma_xfer_ctrl.sv
// Top of the block mover: wires the sequencer, the pointer registers and the bus stage.
// Assumes: cfg_* are stable in the cycle that cfg_start is high.
module dma_xfer_ctrl #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [1:0]        cfg_mode,
    output logic              done,
    output logic              bus_req,
    input  logic              bus_grant,
    input  logic              bus_idle,
    output logic              bus_drive,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              mem_we,
    input  logic              dev_valid,
    input  logic [DATA_W-1:0] dev_data,
    output logic              dev_ack
);
    logic              wr;
    logic              load;
    logic              set_done;
    logic              clr_done;
    logic              last_byte;
    logic              zero_len;
    logic [1:0]        mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  count_q;

    // Zero-length programming is finished at once.
    always_comb zero_len = (cfg_count == '0);

    dma_xfer_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cfg_start),
        .zero_len  (zero_len),
        .mode_in   (cfg_mode),
        .bg        (bus_grant),
        .bus_idle  (bus_idle),
        .dev_valid (dev_valid),
        .last_byte (last_byte),
        .br        (bus_req),
        .wr        (wr),
        .load      (load),
        .set_done  (set_done),
        .clr_done  (clr_done),
        .mode_q    (mode_q)
    );

    dma_xfer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_addr  (cfg_addr),
        .load_count (cfg_count),
        .step       (mem_we),
        .set_done   (set_done),
        .clr_done   (clr_done),
        .addr_q     (addr_q),
        .count_q    (count_q),
        .last_byte  (last_byte),
        .done       (done)
    );

    dma_xfer_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .br        (bus_req),
        .bg        (bus_grant),
        .wr        (wr),
        .addr      (addr_q),
        .dev_data  (dev_data),
        .bus_drive (bus_drive),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_we    (mem_we),
        .dev_ack   (dev_ack)
    );
endmodule

// File: rtl/dma_xfer_chk.sv
// Cycle-level protocol checker for the block mover, bound onto the top.
// Assumes: reset is low from time zero.
module dma_xfer_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_start,
    input logic              bus_req,
    input logic              bus_grant,
    input logic              bus_idle,
    input logic              bus_drive,
    input logic              mem_we,
    input logic              dev_valid,
    input logic              dev_ack,
    input logic              done,
    input logic [1:0]        mode_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic              last_byte
);
    localparam logic [ADDR_W-1:0] STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

    p_write_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (bus_drive && dev_valid && dev_ack));

    p_no_write_ungranted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_grant) |-> !mem_we);

    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !cfg_start) |=> (addr_q == $past(addr_q) + STEP));

    p_hold_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !last_byte && (mode_q[1] == mode_q[0])) |=> bus_req);

    p_steal_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mode_q == 2'b01) |=> !bus_req);

    p_quiet_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mode_q == 2'b10) |-> bus_idle);

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_start) |=> done);

    p_last_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && last_byte) |=> (done && !bus_req));
endmodule

bind dma_xfer_ctrl dma_xfer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_start (cfg_start),
    .bus_req   (bus_req),
    .bus_grant (bus_grant),
    .bus_idle  (bus_idle),
    .bus_drive (bus_drive),
    .mem_we    (mem_we),
    .dev_valid (dev_valid),
    .dev_ack   (dev_ack),
    .done      (done),
    .mode_q    (mode_q),
    .addr_q    (addr_q),
    .last_byte (last_byte)
);

// File: tb/sim_dma_xfer_ctrl.sv
// Directed bench: a processor model grants one cycle after each request; the device streams bytes.
module sim_dma_xfer_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_start = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [7:0]  cfg_count = '0;
    logic [1:0]  cfg_mode = '0;
    logic        done;
    logic        bus_req;
    logic        bus_grant = 1'b0;
    logic        bus_idle = 1'b1;
    logic        bus_drive;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;
    logic        mem_we;
    logic        dev_valid = 1'b0;
    logic [7:0]  dev_data = '0;
    logic        dev_ack;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    dma_xfer_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_addr(cfg_addr),
        .cfg_count(cfg_count), .cfg_mode(cfg_mode), .done(done), .bus_req(bus_req),
        .bus_grant(bus_grant), .bus_idle(bus_idle), .bus_drive(bus_drive),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_we(mem_we),
        .dev_valid(dev_valid), .dev_data(dev_data), .dev_ack(dev_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record one check and report a mismatch.
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: an expired run is a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    // R1: outputs quiet in reset and right after it.
    task automatic t_reset();
        rst_n = 1'b0;
        bus_grant = 1'b1;
        dev_valid = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk({bus_req, mem_we, dev_ack, bus_drive, done} == 5'b0, "R1", "outputs in reset",
            {bus_req, mem_we, dev_ack, bus_drive, done}, 0);
        rst_n = 1'b1;
        bus_grant = 1'b0;
        @(negedge clk);
        #1;
        chk({bus_req, mem_we, dev_ack, bus_drive, done} == 5'b0, "R1", "outputs after reset",
            {bus_req, mem_we, dev_ack, bus_drive, done}, 0);
    endtask

    // Run one block under a policy and check every cycle against the requirements.
    task automatic run_xfer(input logic [1:0] mode, input logic [15:0] a0, input int cnt,
                            input int idle_gap, input int valid_gap, input bit poke,
                            input string mreq);
        int  wr_n = 0;
        bit  prev_br = 1'b0;
        bit  prev_wr = 1'b0;
        bit  prev2_wr = 1'b0;
        bit  fin = 1'b0;
        bit  hold;
        bit  wr_now;
        hold = (mode == 2'b00) || (mode == 2'b11);
        @(negedge clk);
        cfg_addr = a0; cfg_count = 8'(cnt); cfg_mode = mode; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        #1;
        chk(done == 1'b0, "R8", "done cleared by start", done, 0);
        chk(bus_req == 1'b1, mreq, "request after start", bus_req, 1);
        for (int c = 0; c < 300 && !fin; c++) begin
            bus_grant = prev_br;
            bus_idle  = (idle_gap == 0) || (c % idle_gap != 1);
            dev_valid = (valid_gap == 0) || (c % valid_gap != 2);
            dev_data  = 8'(8'h30 + wr_n * 7);
            cfg_start = poke && (c == 3);
            cfg_addr  = poke ? a0 + 16'h0100 : a0;
            cfg_count = poke ? 8'(cnt + 5) : 8'(cnt);
            #1;
            wr_now = mem_we;
            chk(bus_drive == (bus_req && bus_grant), "R2", "drive enable", bus_drive, bus_req && bus_grant);
            if (!bus_drive)
                chk(!mem_we && mem_addr == 0 && mem_data == 0, "R2", "released outputs",
                    {mem_we, mem_addr, mem_data}, 0);
            if (bus_req && !bus_grant) chk(!mem_we, "R2", "write without grant", mem_we, 0);
            if (mode == 2'b10 && !bus_idle) chk(!mem_we, "R7", "write while bus busy", mem_we, 0);
            if (hold && wr_n < cnt) chk(bus_req, mreq, "request held", bus_req, 1);
            if (mode == 2'b01 && wr_n < cnt) begin
                if (prev_wr)  chk(!bus_req, "R6", "gap after byte", bus_req, 0);
                if (prev2_wr) chk(bus_req, "R6", "re-request after gap", bus_req, 1);
            end
            if (mem_we) begin
                chk(mem_addr == 16'(a0 + wr_n), poke ? "R9" : "R4", "write address", mem_addr, 16'(a0 + wr_n));
                chk(mem_data == dev_data, "R3", "write data", mem_data, dev_data);
                chk(dev_ack && dev_valid, "R3", "ack with write", {dev_ack, dev_valid}, 2'b11);
                wr_n++;
            end else begin
                chk(!dev_ack, "R3", "ack without write", dev_ack, 0);
            end
            if (wr_n == cnt && !bus_req && !mem_we) begin
                chk(done, "R8", "done after final byte", done, 1);
                fin = 1'b1;
            end
            prev2_wr = prev_wr;
            prev_wr  = wr_now;
            prev_br  = bus_req;
            @(negedge clk);
            cfg_start = 1'b0;
        end
        chk(wr_n == cnt, poke ? "R9" : "R4", "bytes written", wr_n, cnt);
        bus_grant = 1'b0;
        repeat (3) begin
            #1;
            chk(done && !bus_req, "R8", "done sticky, bus released", {done, bus_req}, 2'b10);
            @(negedge clk);
        end
    endtask

    // R8: zero-length start completes with no request.
    task automatic t_zero();
        t_reset();
        @(negedge clk);
        cfg_count = 8'd0; cfg_mode = 2'b00; cfg_addr = 16'h5555; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        repeat (3) begin
            #1;
            chk(done && !bus_req, "R8", "zero-length start", {done, bus_req}, 2'b10);
            @(negedge clk);
        end
    endtask

    initial begin
        t_reset();
        run_xfer(2'b00, 16'h1000, 6, 0, 4, 1'b0, "R5");
        run_xfer(2'b01, 16'hFFFE, 5, 0, 0, 1'b0, "R6");
        run_xfer(2'b10, 16'h0400, 7, 3, 0, 1'b0, "R7");
        run_xfer(2'b11, 16'h2200, 4, 0, 5, 1'b0, "R10");
        run_xfer(2'b00, 16'h3000, 8, 0, 0, 1'b1, "R9");
        t_zero();
        finish_run();
    end
endmodule